// File: doc/BRIEF.md
# Ethernet Receive DMA with Status and Interrupt Registers

This block is the receive side of an Ethernet DMA engine together with the status and interrupt logic that software shares with it. Frames arrive one byte per handshake on a valid/ready stream. When reception is enabled and a frame starts, the engine fetches the current receive descriptor from host memory. It then writes the frame bytes straight into the descriptor's buffer as the bytes arrive. At the end of the frame it writes the descriptor's control word back with the stored length, moves its ring pointer, raises status bits and bumps the statistics counters.

Frames that are too short, and frames that find no descriptor owned by the engine, are consumed from the stream and discarded. Each of these two cases leaves its own status mark. Software clears status by writing ones, masks it with an enable register, and sees the result on one level interrupt. The register port also holds a fixed identification value, a bus configuration word and the ring base. Address filtering, CRC checking and flow control sit elsewhere.

Top module: `rxdma_top`

## Requirements
- R1: While bit 1 of the control register (word 0) is clear and the engine is idle, `frm_ready` stays low, so no frame is taken and memory is not touched.
- R2: A frame of fewer than 12 bytes sets status bits 6 and 16 (mask 0x0001_0040), and this holds whether or not a descriptor is available. The descriptor control word, the ring pointer (word 4) and every counter stay unchanged.
- R3: A frame of 12 bytes or more that finds bit 31 of the descriptor's first word clear is dropped. It sets status bits 7 and 15 (mask 0x0000_8080), leaves the ring pointer and the counters unchanged, and writes nothing to the buffer.
- R4: A stored frame is written to the address held in descriptor word 2, with byte k at byte address buffer+k, packed little-endian into 32-bit words. Lanes past the frame end in the last word are written as zero. The descriptor's first word becomes ((length+4) << 16) | 0x300, with bit 31 clear, and status bits 6 and 16 are set.
- R5: After a stored frame the ring pointer returns to the ring base when bit 15 of descriptor word 1 is set, and otherwise advances by 32 bytes.
- R6: For each stored frame, the frame counter (word 8) goes up by one and the byte counter (word 9) by the frame length. If the first 6 bytes are all 0xFF, the broadcast counter (word 10) goes up by one. If instead bit 0 of the first byte is 1, the multicast counter (word 11) goes up by one.
- R7: Writing the status register (word 5) clears exactly the bits written as 1. A bit set by the engine in the same cycle as a clear stays set.
- R8: `irq` is high exactly when the status register AND the interrupt-enable register (word 6) is nonzero.
- R9: Word 2 always reads 0x0000_1012. The bus-mode register (word 1) stores the written value with bit 0 forced to 0.
- R10: Writing the ring base (word 3) loads the same value into the ring pointer (word 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| frm_valid | input | 1 | Frame byte valid |
| frm_data | input | 8 | Frame byte |
| frm_last | input | 1 | Marks the final byte of a frame |
| frm_ready | output | 1 | Engine takes the byte this cycle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the request this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the length boundary at 11 versus 12 bytes. A wrong compare there would either store an 11-byte runt with a written-back descriptor or throw away a legal minimum frame. It sends a short frame into a ring with no descriptor available, which catches a design that tests ownership before length and raises the no-descriptor bits instead of the runt bits. Frame lengths that are not a multiple of four show whether the final partial word is written, and written with zero tails. A descriptor with the wrap flag set shows whether the pointer returns to the base instead of running past the ring. Partial write-one-to-clear patterns and changes of the enable mask expose status that clears too much, and an interrupt that ignores the mask.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] RA_CTRL    = 4'd0;
   localparam logic [REG_AW-1:0] RA_BUSMODE = 4'd1;
   localparam logic [REG_AW-1:0] RA_IDENT   = 4'd2;
   localparam logic [REG_AW-1:0] RA_RXBASE  = 4'd3;
   localparam logic [REG_AW-1:0] RA_RXCUR   = 4'd4;
   localparam logic [REG_AW-1:0] RA_STATUS  = 4'd5;
   localparam logic [REG_AW-1:0] RA_INTEN   = 4'd6;
   localparam logic [REG_AW-1:0] RA_FRAMES  = 4'd8;
   localparam logic [REG_AW-1:0] RA_BYTES   = 4'd9;
   localparam logic [REG_AW-1:0] RA_BCAST   = 4'd10;
   localparam logic [REG_AW-1:0] RA_MCAST   = 4'd11;

   localparam logic [31:0] IDENT_VALUE = 32'h0000_1012;

   localparam int CTRL_RX_ON  = 1;
   localparam int DESC_OWN    = 31;
   localparam int SIZE_WRAP   = 15;

   localparam logic [31:0] ST_RX_DONE   = 32'h0000_0040;
   localparam logic [31:0] ST_NO_DESC   = 32'h0000_0080;
   localparam logic [31:0] ST_ABN_SUM   = 32'h0000_8000;
   localparam logic [31:0] ST_NORM_SUM  = 32'h0001_0000;
   localparam logic [31:0] ST_GOOD      = ST_RX_DONE | ST_NORM_SUM;
   localparam logic [31:0] ST_STARVED   = ST_NO_DESC | ST_ABN_SUM;

   localparam logic [15:0] WB_FLAGS     = 16'h0300;
   localparam int          CRC_BYTES    = 4;
   localparam int          MIN_FRAME    = 12;

   localparam int NUM_CNT   = 4;
   localparam int CNT_FRM   = 0;
   localparam int CNT_BYT   = 1;
   localparam int CNT_BC    = 2;
   localparam int CNT_MC    = 3;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_CTL,
      S_RD_SIZE,
      S_RD_BUF,
      S_RECV,
      S_WR_DATA,
      S_WR_DESC,
      S_DROP
   } rx_state_t;

endpackage

// File: rtl/rxdma_classify.sv
module rxdma_classify
   import rxdma_pkg::*;
#(
   parameter int LEN_W      = 14,
   parameter int ADDR_BYTES = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             take,
   input  logic [LEN_W-1:0] idx,
   input  logic [7:0]       data,
   output logic             is_bcast,
   output logic             is_mcast
);

   logic all_ones_q;
   logic group_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         all_ones_q <= 1'b1;
         group_q    <= 1'b0;
      end else if (start) begin
         all_ones_q <= 1'b1;
         group_q    <= 1'b0;
      end else if (take) begin
         if (idx < LEN_W'(ADDR_BYTES)) begin
            all_ones_q <= all_ones_q & (data == 8'hFF);
         end
         if (idx == '0) begin
            group_q <= data[0];
         end
      end
   end

   assign is_bcast = all_ones_q;
   assign is_mcast = group_q & ~all_ones_q;

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
   import rxdma_pkg::*;
#(
   parameter int LEN_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [31:0]      rx_cur,
   input  logic             frm_valid,
   input  logic [7:0]       frm_data,
   input  logic             frm_last,
   output logic             frm_ready,
   output logic             mem_req,
   output logic             mem_we,
   output logic [31:0]      mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_ack,
   output logic [31:0]      st_set,
   output logic             ptr_upd,
   output logic             ptr_wrap,
   output logic             stored,
   output logic [LEN_W-1:0] stored_len,
   output logic             cls_start,
   output logic             take,
   output logic [LEN_W-1:0] byte_idx,
   output logic             busy
);

   rx_state_t        state_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_nx;
   logic [31:0]      wbuf_q;
   logic [31:0]      wr_addr_q;
   logic [31:0]      buf_addr_q;
   logic             wrap_q;
   logic             last_q;
   logic [15:0]      len_crc;
   logic             runt_now;
   logic             runt_next;

   assign len_nx    = len_q + LEN_W'(1);
   assign len_crc   = 16'(len_q) + 16'(CRC_BYTES);
   assign runt_now  = len_q  < LEN_W'(MIN_FRAME);
   assign runt_next = len_nx < LEN_W'(MIN_FRAME);

   assign frm_ready = (state_q == S_RECV) || (state_q == S_DROP);
   assign take      = frm_valid && frm_ready;
   assign byte_idx  = len_q;
   assign busy      = (state_q != S_IDLE);
   assign cls_start = (state_q == S_IDLE) && rx_en && frm_valid;
   assign ptr_wrap  = wrap_q;
   assign stored_len = len_q;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = rx_cur;
      mem_wdata = '0;
      unique case (state_q)
         S_RD_CTL:  begin mem_req = 1'b1; mem_addr = rx_cur; end
         S_RD_SIZE: begin mem_req = 1'b1; mem_addr = rx_cur + 32'd4; end
         S_RD_BUF:  begin mem_req = 1'b1; mem_addr = rx_cur + 32'd8; end
         S_WR_DATA: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = wr_addr_q;
            mem_wdata = wbuf_q;
         end
         S_WR_DESC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = rx_cur;
            mem_wdata = {len_crc, WB_FLAGS};
         end
         default: ;
      endcase
   end

   always_comb begin
      st_set  = '0;
      ptr_upd = 1'b0;
      stored  = 1'b0;
      if (state_q == S_WR_DATA && mem_ack && last_q && runt_now) begin
         st_set = ST_GOOD;
      end
      if (state_q == S_WR_DESC && mem_ack) begin
         st_set  = ST_GOOD;
         ptr_upd = 1'b1;
         stored  = 1'b1;
      end
      if (state_q == S_DROP && take && frm_last) begin
         st_set = runt_next ? ST_GOOD : ST_STARVED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         len_q      <= '0;
         wbuf_q     <= '0;
         wr_addr_q  <= '0;
         buf_addr_q <= '0;
         wrap_q     <= 1'b0;
         last_q     <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (cls_start) begin
                  state_q <= S_RD_CTL;
                  len_q   <= '0;
                  wbuf_q  <= '0;
                  last_q  <= 1'b0;
               end
            end
            S_RD_CTL: begin
               if (mem_ack) begin
                  state_q <= mem_rdata[DESC_OWN] ? S_RD_SIZE : S_DROP;
               end
            end
            S_RD_SIZE: begin
               if (mem_ack) begin
                  wrap_q  <= mem_rdata[SIZE_WRAP];
                  state_q <= S_RD_BUF;
               end
            end
            S_RD_BUF: begin
               if (mem_ack) begin
                  buf_addr_q <= mem_rdata;
                  state_q    <= S_RECV;
               end
            end
            S_RECV: begin
               if (take) begin
                  wbuf_q[8*len_q[1:0] +: 8] <= frm_data;
                  len_q     <= len_nx;
                  last_q    <= frm_last;
                  wr_addr_q <= buf_addr_q +
                               {{(32-LEN_W){1'b0}}, len_q[LEN_W-1:2], 2'b00};
                  if (len_q[1:0] == 2'd3 || frm_last) begin
                     state_q <= S_WR_DATA;
                  end
               end
            end
            S_WR_DATA: begin
               if (mem_ack) begin
                  wbuf_q <= '0;
                  if (!last_q) begin
                     state_q <= S_RECV;
                  end else if (runt_now) begin
                     state_q <= S_IDLE;
                  end else begin
                     state_q <= S_WR_DESC;
                  end
               end
            end
            S_WR_DESC: begin
               if (mem_ack) begin
                  state_q <= S_IDLE;
               end
            end
            S_DROP: begin
               if (take) begin
                  len_q <= len_nx;
                  if (frm_last) begin
                     state_q <= S_IDLE;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rxdma_regs.sv
module rxdma_regs
   import rxdma_pkg::*;
#(
   parameter int LEN_W      = 14,
   parameter int CNT_W      = 32,
   parameter int DESC_BYTES = 32,
   parameter bit IRQ_FLOP   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [31:0]       st_set,
   input  logic              ptr_upd,
   input  logic              ptr_wrap,
   input  logic              stored,
   input  logic [LEN_W-1:0]  stored_len,
   input  logic              is_bcast,
   input  logic              is_mcast,
   output logic              rx_en,
   output logic [31:0]       rx_cur,
   output logic [31:0]       rx_base,
   output logic [31:0]       status,
   output logic [31:0]       inten,
   output logic [CNT_W-1:0]  frame_cnt,
   output logic              irq
);

   logic [31:0] ctrl_q;
   logic [31:0] bus_q;
   logic [31:0] base_q;
   logic [31:0] cur_q;
   logic [31:0] status_q;
   logic [31:0] inten_q;
   logic [31:0] clr_mask;
   logic        base_wr;
   logic [CNT_W-1:0] cnt_val [NUM_CNT];
   logic [CNT_W-1:0] cnt_inc [NUM_CNT];

   assign base_wr  = reg_we && (reg_addr == RA_RXBASE);
   assign clr_mask = (reg_we && reg_addr == RA_STATUS) ? reg_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         bus_q    <= '0;
         inten_q  <= '0;
         status_q <= '0;
      end else begin
         if (reg_we && reg_addr == RA_CTRL)    ctrl_q  <= reg_wdata;
         if (reg_we && reg_addr == RA_BUSMODE) bus_q   <= reg_wdata & ~32'h1;
         if (reg_we && reg_addr == RA_INTEN)   inten_q <= reg_wdata;
         status_q <= (status_q & ~clr_mask) | st_set;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (base_wr) begin
         base_q <= reg_wdata;
         cur_q  <= reg_wdata;
      end else if (ptr_upd) begin
         cur_q <= ptr_wrap ? base_q : cur_q + 32'(DESC_BYTES);
      end
   end

   always_comb begin
      cnt_inc[CNT_FRM] = stored ? CNT_W'(1) : '0;
      cnt_inc[CNT_BYT] = stored ? CNT_W'(stored_len) : '0;
      cnt_inc[CNT_BC]  = (stored && is_bcast) ? CNT_W'(1) : '0;
      cnt_inc[CNT_MC]  = (stored && is_mcast) ? CNT_W'(1) : '0;
   end

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= q + cnt_inc[g];
      end
      assign cnt_val[g] = q;
   end

   if (IRQ_FLOP) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(status_q & inten_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(status_q & inten_q);
   end

   always_comb begin
      unique case (reg_addr)
         RA_CTRL:    reg_rdata = ctrl_q;
         RA_BUSMODE: reg_rdata = bus_q;
         RA_IDENT:   reg_rdata = IDENT_VALUE;
         RA_RXBASE:  reg_rdata = base_q;
         RA_RXCUR:   reg_rdata = cur_q;
         RA_STATUS:  reg_rdata = status_q;
         RA_INTEN:   reg_rdata = inten_q;
         RA_FRAMES:  reg_rdata = 32'(cnt_val[CNT_FRM]);
         RA_BYTES:   reg_rdata = 32'(cnt_val[CNT_BYT]);
         RA_BCAST:   reg_rdata = 32'(cnt_val[CNT_BC]);
         RA_MCAST:   reg_rdata = 32'(cnt_val[CNT_MC]);
         default:    reg_rdata = '0;
      endcase
   end

   assign rx_en     = ctrl_q[CTRL_RX_ON];
   assign rx_cur    = cur_q;
   assign rx_base   = base_q;
   assign status    = status_q;
   assign inten     = inten_q;
   assign frame_cnt = cnt_val[CNT_FRM];

endmodule

// File: rtl/rxdma_top.sv
module rxdma_top
   import rxdma_pkg::*;
#(
   parameter int LEN_W      = 14,
   parameter int CNT_W      = 32,
   parameter int DESC_BYTES = 32,
   parameter int ADDR_BYTES = 6,
   parameter bit IRQ_FLOP   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        frm_valid,
   input  logic [7:0]  frm_data,
   input  logic        frm_last,
   output logic        frm_ready,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   input  logic        mem_ack,
   output logic        irq
);

   if (LEN_W < 6 || LEN_W > 15) begin : g_bad_len
      initial $fatal(1, "rxdma_top: LEN_W must lie in 6..15");
   end
   if (CNT_W < LEN_W || CNT_W > 32) begin : g_bad_cnt
      initial $fatal(1, "rxdma_top: CNT_W must lie in LEN_W..32");
   end
   if (DESC_BYTES < 12 || (DESC_BYTES % 4) != 0) begin : g_bad_desc
      initial $fatal(1, "rxdma_top: DESC_BYTES must be a multiple of 4, at least 12");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > MIN_FRAME) begin : g_bad_addr
      initial $fatal(1, "rxdma_top: ADDR_BYTES out of range");
   end

   logic             rx_en;
   logic [31:0]      rx_cur;
   logic [31:0]      rx_base;
   logic [31:0]      status;
   logic [31:0]      inten;
   logic [CNT_W-1:0] frame_cnt;
   logic [31:0]      st_set;
   logic             ptr_upd;
   logic             ptr_wrap;
   logic             stored;
   logic [LEN_W-1:0] stored_len;
   logic             cls_start;
   logic             take;
   logic [LEN_W-1:0] byte_idx;
   logic             busy;
   logic             is_bcast;
   logic             is_mcast;

   rxdma_engine #(.LEN_W(LEN_W)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en),
      .rx_cur     (rx_cur),
      .frm_valid  (frm_valid),
      .frm_data   (frm_data),
      .frm_last   (frm_last),
      .frm_ready  (frm_ready),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_ack    (mem_ack),
      .st_set     (st_set),
      .ptr_upd    (ptr_upd),
      .ptr_wrap   (ptr_wrap),
      .stored     (stored),
      .stored_len (stored_len),
      .cls_start  (cls_start),
      .take       (take),
      .byte_idx   (byte_idx),
      .busy       (busy)
   );

   rxdma_classify #(.LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES)) u_classify (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cls_start),
      .take     (take),
      .idx      (byte_idx),
      .data     (frm_data),
      .is_bcast (is_bcast),
      .is_mcast (is_mcast)
   );

   rxdma_regs #(
      .LEN_W      (LEN_W),
      .CNT_W      (CNT_W),
      .DESC_BYTES (DESC_BYTES),
      .IRQ_FLOP   (IRQ_FLOP)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .st_set     (st_set),
      .ptr_upd    (ptr_upd),
      .ptr_wrap   (ptr_wrap),
      .stored     (stored),
      .stored_len (stored_len),
      .is_bcast   (is_bcast),
      .is_mcast   (is_mcast),
      .rx_en      (rx_en),
      .rx_cur     (rx_cur),
      .rx_base    (rx_base),
      .status     (status),
      .inten      (inten),
      .frame_cnt  (frame_cnt),
      .irq        (irq)
   );

endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker
   import rxdma_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int DESC_BYTES = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [3:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             frm_ready,
   input logic             busy,
   input logic             rx_en,
   input logic             mem_req,
   input logic             mem_we,
   input logic [31:0]      mem_addr,
   input logic [31:0]      mem_wdata,
   input logic             mem_ack,
   input logic [31:0]      rx_cur,
   input logic [31:0]      rx_base,
   input logic [31:0]      status,
   input logic [31:0]      inten,
   input logic [31:0]      st_set,
   input logic [CNT_W-1:0] frame_cnt,
   input logic             irq
);

   logic base_wr;
   logic desc_wb;
   assign base_wr = reg_we && (reg_addr == RA_RXBASE);
   assign desc_wb = mem_req && mem_we && mem_ack && (mem_addr == rx_cur);

   AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !busy) |-> !frm_ready);  // R1

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R4

   AST_DESC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_addr == rx_cur) |-> (mem_wdata[15:0] == WB_FLAGS && !mem_wdata[31]));  // R4

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(rx_cur) && !$past(base_wr)) |-> ((rx_cur == $past(rx_cur) + 32'(DESC_BYTES)) || (rx_cur == rx_base)));  // R5

   AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_cnt) |-> ($past(desc_wb) && frame_cnt == $past(frame_cnt) + CNT_W'(1)));  // R6

   AST_W1C_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_STATUS && reg_wdata == 32'hFFFF_FFFF && st_set == '0) |=> (status == '0));  // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_set != '0) |=> ((status & $past(st_set)) == $past(st_set)));  // R7

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (inten == '0 && $past(inten) == '0) |-> !irq);  // R8

   AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_IDENT) |-> (reg_rdata == IDENT_VALUE));  // R9

   AST_BUSMODE_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_BUSMODE) |-> !reg_rdata[0]);  // R9

   AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> (rx_cur == $past(reg_wdata) && rx_base == $past(reg_wdata)));  // R10

endmodule

bind rxdma_top rxdma_checker #(.CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .frm_ready (frm_ready),
   .busy      (busy),
   .rx_en     (rx_en),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .rx_cur    (rx_cur),
   .rx_base   (rx_base),
   .status    (status),
   .inten     (inten),
   .st_set    (st_set),
   .frame_cnt (frame_cnt),
   .irq       (irq)
);

// File: tb/sim_rxdma_top.sv
module sim_rxdma_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        frm_valid = 1'b0;
   logic [7:0]  frm_data = '0;
   logic        frm_last = 1'b0;
   logic        frm_ready;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        mem_ack;
   logic        irq;

   logic [31:0] mem [0:1023];
   logic        bw_en = 1'b0;
   logic [9:0]  bw_idx = '0;
   logic [31:0] bw_data = '0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr[11:2]];

   always @(posedge clk) begin
      if (bw_en)                  mem[bw_idx] <= bw_data;
      else if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
   end

   rxdma_top u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .frm_valid(frm_valid), .frm_data(frm_data), .frm_last(frm_last), .frm_ready(frm_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
   );

   // {wrap, owned, kind[1:0], len[7:0]}; kind 0 unicast, 1 broadcast, 2 multicast
   localparam logic [11:0] VEC [8] = '{
      {1'b0, 1'b1, 2'd0, 8'd60},
      {1'b0, 1'b1, 2'd1, 8'd12},
      {1'b0, 1'b1, 2'd0, 8'd11},
      {1'b0, 1'b1, 2'd2, 8'd13},
      {1'b0, 1'b0, 2'd0, 8'd20},
      {1'b0, 1'b0, 2'd0, 8'd5},
      {1'b1, 1'b1, 2'd1, 8'd17},
      {1'b0, 1'b1, 2'd2, 8'd64}
   };

   localparam logic [31:0] BASE = 32'h100;

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic mput(input logic [31:0] byte_addr, input logic [31:0] d);
      @(negedge clk);
      bw_en = 1'b1; bw_idx = byte_addr[11:2]; bw_data = d;
      @(negedge clk);
      bw_en = 1'b0;
   endtask

   function automatic logic [7:0] fbyte(input int kind, input int i, input int len);
      if (i < 6) begin
         if (kind == 1) return 8'hFF;
         if (i == 0) return (kind == 2) ? 8'h01 : 8'h02;
         return 8'(8'h30 + i);
      end
      return 8'((i * 7 + len) & 255);
   endfunction

   task automatic send(input int kind, input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         frm_valid = 1'b1;
         frm_data  = fbyte(kind, i, len);
         frm_last  = (i == len - 1);
         #1;
         while (!frm_ready) begin
            @(negedge clk);
            #1;
         end
         @(posedge clk);
      end
      @(negedge clk);
      frm_valid = 1'b0;
      frm_last  = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] cur;
      logic [31:0] exp_frames, exp_bytes, exp_bc, exp_mc;
      int          seen_ready;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(4'd5, v);  chk("R7 status after reset", v, 32'h0);
      chk("R8 irq after reset", {31'b0, irq}, 32'h0);
      rd(4'd2, v);  chk("R9 identification value", v, 32'h0000_1012);
      rd(4'd4, v);  chk("R10 ring pointer after reset", v, 32'h0);
      rd(4'd8, v);  chk("R6 frame counter after reset", v, 32'h0);

      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd1, v);  chk("R9 bus mode bit0 forced low", v, 32'hFFFF_FFFE);
      wr(4'd1, 32'h0000_1235);
      rd(4'd1, v);  chk("R9 bus mode stored value", v, 32'h0000_1234);

      wr(4'd3, BASE);
      rd(4'd4, v);  chk("R10 base write loads pointer", v, BASE);

      // reception disabled: no byte taken
      seen_ready = 0;
      @(negedge clk);
      frm_valid = 1'b1; frm_data = 8'h02; frm_last = 1'b0;
      for (int i = 0; i < 12; i++) begin
         #1 if (frm_ready) seen_ready++;
         @(negedge clk);
      end
      frm_valid = 1'b0;
      chk("R1 ready low while disabled", seen_ready, 0);
      rd(4'd5, v);  chk("R1 no status while disabled", v, 32'h0);

      wr(4'd0, 32'h0000_0002);

      cur = BASE;
      exp_frames = 0; exp_bytes = 0; exp_bc = 0; exp_mc = 0;
      for (int n = 0; n < 8; n++) begin
         int len;
         int kind;
         logic own, wrp, good;
         logic [31:0] bufa, w0, exp_st, exp_cur;
         len  = int'(VEC[n][7:0]);
         kind = int'(VEC[n][9:8]);
         own  = VEC[n][10];
         wrp  = VEC[n][11];
         bufa = 32'h800 + ((cur - BASE) / 32) * 32'h100;
         w0   = own ? 32'h8000_0000 : 32'h0;
         mput(cur,        w0);
         mput(cur + 4,    wrp ? 32'h0000_8100 : 32'h0000_0100);
         mput(cur + 8,    bufa);
         for (int k = 0; k < 17; k++) mput(bufa + 32'(4 * k), 32'hDEAD_BEEF);
         wr(4'd5, 32'hFFFF_FFFF);

         send(kind, len);
         repeat (6) @(negedge clk);

         good    = own && (len >= 12);
         exp_st  = (len < 12) ? 32'h0001_0040 : (!own ? 32'h0000_8080 : 32'h0001_0040);
         exp_cur = good ? (wrp ? BASE : cur + 32) : cur;
         if (good) begin
            exp_frames++;
            exp_bytes += 32'(len);
            if (kind == 1) exp_bc++;
            if (kind == 2) exp_mc++;
         end

         rd(4'd5, v);
         chk((len < 12) ? "R2 runt status" : (own ? "R4 stored status" : "R3 no-descriptor status"), v, exp_st);
         chk(good ? "R4 descriptor written back" : "R2 R3 descriptor untouched", mem[cur[11:2]],
             good ? ({16'(len + 4), 16'h0300}) : w0);
         rd(4'd4, v);
         chk(good ? "R5 pointer step or wrap" : "R2 R3 pointer unchanged", v, exp_cur);
         rd(4'd8,  v); chk("R6 frame counter", v, exp_frames);
         rd(4'd9,  v); chk("R6 byte counter", v, exp_bytes);
         rd(4'd10, v); chk("R6 broadcast counter", v, exp_bc);
         rd(4'd11, v); chk("R6 multicast counter", v, exp_mc);
         if (good) begin
            for (int k = 0; k < (len + 3) / 4; k++) begin
               logic [31:0] ew;
               for (int l = 0; l < 4; l++) begin
                  ew[8*l +: 8] = (4 * k + l < len) ? fbyte(kind, 4 * k + l, len) : 8'h00;
               end
               chk("R4 buffer word", mem[bufa[11:2] + 10'(k)], ew);
            end
            chk("R4 word past frame untouched", mem[bufa[11:2] + 10'((len + 3) / 4)], 32'hDEAD_BEEF);
         end else if (!own && len >= 12) begin
            chk("R3 buffer untouched", mem[bufa[11:2]], 32'hDEAD_BEEF);
         end
         cur = exp_cur;
      end

      // write-one-to-clear and interrupt mask; status is now 0x0001_0040
      wr(4'd5, 32'h0000_0040);
      rd(4'd5, v);  chk("R7 partial clear", v, 32'h0001_0000);
      wr(4'd6, 32'h0001_0000);
      #1 chk("R8 irq with enabled bit", {31'b0, irq}, 32'h1);
      wr(4'd6, 32'h0000_0040);
      #1 chk("R8 irq masked", {31'b0, irq}, 32'h0);
      wr(4'd6, 32'h0001_0000);
      wr(4'd5, 32'h0001_0000);
      rd(4'd5, v);  chk("R7 clear last bit", v, 32'h0);
      chk("R8 irq after clear", {31'b0, irq}, 32'h0);
      rd(4'd2, v);  chk("R9 identification after traffic", v, 32'h0000_1012);

      summary();
   end

endmodule